// File: doc/BRIEF.md
# Overflow Event Timer

This block is a general-purpose timer whose counter only ever counts upward and flags an event when it rolls over from its all-ones value. Software obtains an event after N counting cycles by writing the complement distance (all-ones minus N) into the counter and then setting the run bit. With the reload bit set, every rollover copies the stored reload value back into the counter, so the event repeats with a fixed period. A reload value of zero turns the block into a free-running time base that can be read at any time. With the reload bit clear, the first rollover stops the timer.

The block is programmed through a small synchronous register port. Writes are sampled on the rising clock edge. Reads are combinational from the address. A sync-mode bit routes writes to the control, counter and reload registers through a delay path. In that mode each write lands a fixed number of edges late, and a per-register pending flag can be read while the write is in flight.

Register map: address 0 is control (bit 0 run, bit 1 reload), 1 is the counter, 2 is the reload value, 3 is the interrupt enable (bit 0), 4 is the rollover status (bit 0, write one to clear), 5 is the sync mode (bit 0) and 6 holds the pending flags (read only). Any other address reads as zero.

Top module: `gpt_ovf_timer`

## Requirements
- R1: While the run bit (address 0, bit 0) is set, the counter (address 1) increases by one on every clock edge.
- R2: The status bit (address 4, bit 0) is set on the edge after the counter holds all-ones while running. If the counter holds all-ones minus N when run is written, status is still clear N edges after that write and is set on the edge after that.
- R3: With the reload bit (address 0, bit 1) set, a rollover loads the counter from the reload register and run stays set, so the period is the distance to all-ones plus one.
- R4: With the reload bit clear, a rollover clears the run bit and leaves the counter at zero, where it then stays.
- R5: Writing 1 to address 4 bit 0 clears the status. Writing 0 there has no effect. A rollover on the same edge as a clearing write leaves the status set.
- R6: The irq_o output is high exactly when both the status bit and the enable bit (address 3, bit 0) are set.
- R7: Writing the reload register (address 2) does not change the counter, and the written value reads back.
- R8: With sync mode (address 5, bit 0) set, a write to address 0, 1 or 2 takes effect on the SYNC_LAT-th edge after the edge that samples it (3 by default). Until then, pending bit 0, 1 or 2 of address 6 respectively reads 1.
- R9: In sync mode, a write to a register whose pending bit is set is discarded.
- R10: Clearing the run bit freezes the counter, and the frozen value reads back unchanged.
- R11: After reset, every register reads zero and irq_o is low.
- R12: With reload value 0 and the reload bit set, the counter wraps from all-ones to zero and keeps counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_o | output | 1 | Rollover interrupt |

## Verification
Most internal faults show up within a few edges. A wrong increment or reload path puts a wrong counter value on the read port on the very next edge. A wrong rollover decision moves the status bit, and with it irq_o, early or late by exactly the error, which the bench measures edge by edge against the programmed distance. A fault in the sync-mode delay path shows as a pending flag clearing on the wrong edge, or as a discarded write that lands anyway. Both become visible by the third edge after the write.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_COUNT = 3'd1,
    A_LOAD  = 3'd2,
    A_IEN   = 3'd3,
    A_ISTAT = 3'd4,
    A_SYNC  = 3'd5,
    A_PEND  = 3'd6
  } gpt_addr_e;

  localparam int CTRL_W  = 2;
  localparam int PEND_W  = 3;
endpackage

// File: rtl/gpt_post_slot.sv
module gpt_post_slot #(
  parameter int DATA_W   = 32,
  parameter int SYNC_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              posted_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              land_o,
  output logic [DATA_W-1:0] land_data_o,
  output logic              pend_o
);
  localparam int CW = (SYNC_LAT > 1) ? $clog2(SYNC_LAT) : 1;

  logic              busy_q, busy_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              accept, busy_land;

  always_comb begin
    accept    = posted_i && wr_i && !busy_q;
    busy_land = busy_q && (cnt_q == '0);
    busy_n    = busy_q;
    cnt_n     = cnt_q;
    data_n    = data_q;
    if (busy_land) begin
      busy_n = 1'b0;
    end else if (accept) begin
      busy_n = 1'b1;
      cnt_n  = CW'(SYNC_LAT - 1);
      data_n = wdata_i;
    end else if (busy_q) begin
      cnt_n  = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      data_q <= data_n;
    end
  end

  assign land_o      = busy_land || (!posted_i && wr_i);
  assign land_data_o = busy_land ? data_q : wdata_i;
  assign pend_o      = busy_q;

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(data_q)); // R9
  AST_LAND_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_land |=> !busy_q); // R8
endmodule

// File: rtl/gpt_count_core.sv
module gpt_count_core #(
  parameter int CNT_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctrl_wr_i,
  input  logic [gpt_pkg::CTRL_W-1:0] ctrl_wdata_i,
  input  logic                     cnt_wr_i,
  input  logic [CNT_W-1:0]         cnt_wdata_i,
  input  logic [CNT_W-1:0]         load_i,
  output logic                     run_o,
  output logic                     arl_o,
  output logic [CNT_W-1:0]         count_o,
  output logic                     ovf_o
);
  logic             run_q, run_n;
  logic             arl_q, arl_n;
  logic [CNT_W-1:0] count_q, count_n;
  logic             ovf;

  always_comb begin
    ovf     = run_q && (count_q == '1);
    run_n   = run_q;
    arl_n   = arl_q;
    count_n = count_q;
    if (ctrl_wr_i) begin
      run_n = ctrl_wdata_i[0];
      arl_n = ctrl_wdata_i[1];
    end else if (ovf && !arl_q) begin
      run_n = 1'b0;
    end
    if (cnt_wr_i) begin
      count_n = cnt_wdata_i;
    end else if (ovf) begin
      count_n = arl_q ? load_i : '0;
    end else if (run_q) begin
      count_n = count_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      arl_q   <= 1'b0;
      count_q <= '0;
    end else begin
      run_q   <= run_n;
      arl_q   <= arl_n;
      count_q <= count_n;
    end
  end

  assign run_o   = run_q;
  assign arl_o   = arl_q;
  assign count_o = count_q;
  assign ovf_o   = ovf;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !ovf && !cnt_wr_i) |=> (count_q == $past(count_q) + CNT_W'(1))); // R1
  AST_RELOAD_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && arl_q && !cnt_wr_i && !ctrl_wr_i) |=> (run_q && count_q == $past(load_i))); // R3
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !arl_q && !cnt_wr_i && !ctrl_wr_i) |=> (!run_q && count_q == '0)); // R4
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_wr_i) |=> $stable(count_q)); // R10
endmodule

// File: rtl/gpt_irq_unit.sv
module gpt_irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_i,
  input  logic en_wr_i,
  input  logic stat_wr_i,
  input  logic wbit_i,
  output logic en_o,
  output logic stat_o,
  output logic irq_o
);
  logic en_q, en_n;
  logic stat_q, stat_n;

  always_comb begin
    en_n   = en_wr_i ? wbit_i : en_q;
    stat_n = stat_q;
    if (stat_wr_i && wbit_i) stat_n = 1'b0;
    if (ovf_i)               stat_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      en_q   <= en_n;
      stat_q <= stat_n;
    end
  end

  assign en_o   = en_q;
  assign stat_o = stat_q;
  assign irq_o  = en_q & stat_q;

  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_i |=> stat_q); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_i && wbit_i && !ovf_i) |=> !stat_q); // R5
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_i && en_q && !en_wr_i) |=> irq_o); // R6
endmodule

// File: rtl/gpt_ovf_timer.sv
module gpt_ovf_timer #(
  parameter int CNT_W    = 32,
  parameter int SYNC_LAT = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [gpt_pkg::ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]           reg_wdata,
  output logic [CNT_W-1:0]           reg_rdata,
  output logic                       irq_o
);
  import gpt_pkg::*;

  logic                sync_q, sync_n;
  logic [CNT_W-1:0]    load_q, load_n;
  logic                wr_ctrl, wr_count, wr_load, wr_ien, wr_istat, wr_sync;
  logic                ctrl_land, count_land, load_land;
  logic [CTRL_W-1:0]   ctrl_data;
  logic [CNT_W-1:0]    count_data, load_data;
  logic [PEND_W-1:0]   pend;
  logic                run, arl, ovf, ien, istat;
  logic [CNT_W-1:0]    count;

  always_comb begin
    wr_ctrl  = reg_we && (reg_addr == A_CTRL);
    wr_count = reg_we && (reg_addr == A_COUNT);
    wr_load  = reg_we && (reg_addr == A_LOAD);
    wr_ien   = reg_we && (reg_addr == A_IEN);
    wr_istat = reg_we && (reg_addr == A_ISTAT);
    wr_sync  = reg_we && (reg_addr == A_SYNC);
  end

  gpt_post_slot #(.DATA_W(CTRL_W), .SYNC_LAT(SYNC_LAT)) ctrl_slot_i (
    .clk(clk), .rst_n(rst_n), .posted_i(sync_q), .wr_i(wr_ctrl),
    .wdata_i(reg_wdata[CTRL_W-1:0]), .land_o(ctrl_land),
    .land_data_o(ctrl_data), .pend_o(pend[0]));

  gpt_post_slot #(.DATA_W(CNT_W), .SYNC_LAT(SYNC_LAT)) count_slot_i (
    .clk(clk), .rst_n(rst_n), .posted_i(sync_q), .wr_i(wr_count),
    .wdata_i(reg_wdata), .land_o(count_land),
    .land_data_o(count_data), .pend_o(pend[1]));

  gpt_post_slot #(.DATA_W(CNT_W), .SYNC_LAT(SYNC_LAT)) load_slot_i (
    .clk(clk), .rst_n(rst_n), .posted_i(sync_q), .wr_i(wr_load),
    .wdata_i(reg_wdata), .land_o(load_land),
    .land_data_o(load_data), .pend_o(pend[2]));

  always_comb begin
    sync_n = wr_sync ? reg_wdata[0] : sync_q;
    load_n = load_land ? load_data : load_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      load_q <= '0;
    end else begin
      sync_q <= sync_n;
      load_q <= load_n;
    end
  end

  gpt_count_core #(.CNT_W(CNT_W)) core_i (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr_i(ctrl_land), .ctrl_wdata_i(ctrl_data),
    .cnt_wr_i(count_land), .cnt_wdata_i(count_data),
    .load_i(load_q), .run_o(run), .arl_o(arl),
    .count_o(count), .ovf_o(ovf));

  gpt_irq_unit irq_i (
    .clk(clk), .rst_n(rst_n), .ovf_i(ovf),
    .en_wr_i(wr_ien), .stat_wr_i(wr_istat), .wbit_i(reg_wdata[0]),
    .en_o(ien), .stat_o(istat), .irq_o(irq_o));

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {{(CNT_W-2){1'b0}}, arl, run};
      A_COUNT: reg_rdata = count;
      A_LOAD:  reg_rdata = load_q;
      A_IEN:   reg_rdata = {{(CNT_W-1){1'b0}}, ien};
      A_ISTAT: reg_rdata = {{(CNT_W-1){1'b0}}, istat};
      A_SYNC:  reg_rdata = {{(CNT_W-1){1'b0}}, sync_q};
      A_PEND:  reg_rdata = {{(CNT_W-PEND_W){1'b0}}, pend};
      default: reg_rdata = '0;
    endcase
  end

  AST_LOAD_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (load_land && !count_land && !run) |=> $stable(count)); // R7
endmodule

// File: tb/gpt_ovf_timer_tb_top.sv
`timescale 1ns/1ps
module gpt_ovf_timer_tb_top;
  localparam logic [31:0] MAXV = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  gpt_ovf_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

  // expected counter value after k increments from c
  function automatic logic [31:0] f_adv(input logic [31:0] c, input int k);
    return c + 32'(k);
  endfunction

  // complement distance: value to load for an event after n cycles
  function automatic logic [31:0] f_dist(input int n);
    return MAXV - 32'(n);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, x, a, b, old;
    int n, p;
    void'($urandom(32'h0000_5eed));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v); chk("R11", v, 32'h0);
    end
    chk("R11 irq", {31'b0, irq_o}, 32'h0);

    // R7 reload register write leaves counter alone
    x = $urandom;
    wr(3'd2, x);
    rd(3'd2, v); chk("R7 readback", v, x);
    rd(3'd1, v); chk("R7 count", v, 32'h0);

    // R1 counting and R10 freeze
    wr(3'd1, 32'd100);
    wr(3'd0, 32'd1);
    n = int'($urandom_range(1, 30));
    step(n);
    rd(3'd1, v); chk("R1", v, f_adv(32'd100, n));
    wr(3'd0, 32'd0);
    step(3);
    rd(3'd1, v); chk("R10", v, f_adv(32'd100, n + 1));

    // R2/R4/R5 random one-shot distances
    for (int it = 0; it < 6; it++) begin
      n = int'($urandom_range(1, 40));
      wr(3'd1, f_dist(n));
      wr(3'd0, 32'd1);
      step(n);
      rd(3'd4, v); chk("R2 early", v, 32'h0);
      step(1);
      rd(3'd4, v); chk("R2 set", v, 32'h1);
      rd(3'd0, v); chk("R4 run", v, 32'h0);
      step(2);
      rd(3'd1, v); chk("R4 count", v, 32'h0);
      wr(3'd4, 32'h0);
      rd(3'd4, v); chk("R5 zero", v, 32'h1);
      wr(3'd4, 32'h1);
      rd(3'd4, v); chk("R5 clear", v, 32'h0);
    end

    // R3 random periods with auto reload
    for (int it = 0; it < 4; it++) begin
      p = int'($urandom_range(1, 25));
      wr(3'd2, f_dist(p));
      wr(3'd1, f_dist(p));
      wr(3'd0, 32'd3);
      step(p + 1);
      rd(3'd4, v); chk("R3 stat", v, 32'h1);
      rd(3'd1, v); chk("R3 reload", v, f_dist(p));
      rd(3'd0, v); chk("R3 run", v, 32'h3);
      step(p + 1);
      rd(3'd1, v); chk("R3 period", v, f_dist(p));
      wr(3'd0, 32'd0);
      wr(3'd4, 32'h1);
    end

    // R12 free running wrap
    wr(3'd2, 32'h0);
    wr(3'd1, f_dist(2));
    wr(3'd0, 32'd3);
    step(4);
    rd(3'd1, v); chk("R12 wrap", v, 32'h1);
    rd(3'd4, v); chk("R12 stat", v, 32'h1);
    wr(3'd0, 32'd0);
    wr(3'd4, 32'h1);

    // R6 interrupt gating
    wr(3'd1, MAXV);
    wr(3'd0, 32'd1);
    step(1);
    chk("R6 masked", {31'b0, irq_o}, 32'h0);
    wr(3'd3, 32'h1);
    chk("R6 raised", {31'b0, irq_o}, 32'h1);
    wr(3'd3, 32'h0);
    chk("R6 disabled", {31'b0, irq_o}, 32'h0);
    wr(3'd3, 32'h1);
    wr(3'd4, 32'h1);
    chk("R6 cleared", {31'b0, irq_o}, 32'h0);
    wr(3'd3, 32'h0);

    // R5 rollover wins over same-edge clear
    wr(3'd1, MAXV);
    wr(3'd0, 32'd1);
    wr(3'd4, 32'h1);
    rd(3'd4, v); chk("R5 set wins", v, 32'h1);
    wr(3'd4, 32'h1);

    // R8 posted counter write
    wr(3'd5, 32'h1);
    rd(3'd1, old);
    x = $urandom;
    wr(3'd1, x);
    rd(3'd6, v); chk("R8 pend", v, 32'h2);
    rd(3'd1, v); chk("R8 old", v, old);
    step(2);
    rd(3'd6, v); chk("R8 pend late", v, 32'h2);
    rd(3'd1, v); chk("R8 not yet", v, old);
    step(1);
    rd(3'd6, v); chk("R8 landed pend", v, 32'h0);
    rd(3'd1, v); chk("R8 landed", v, x);

    // R9 second write while pending is dropped
    a = $urandom; b = ~a;
    wr(3'd1, a);
    wr(3'd1, b);
    step(2);
    rd(3'd1, v); chk("R9 count", v, a);
    step(3);
    rd(3'd1, v); chk("R9 count stays", v, a);
    a = $urandom; b = a ^ 32'h00F0_0F00;
    wr(3'd2, a);
    rd(3'd6, v); chk("R8 load pend", v, 32'h4);
    wr(3'd2, b);
    step(2);
    rd(3'd2, v); chk("R9 load", v, a);
    wr(3'd0, 32'd2);
    rd(3'd6, v); chk("R8 ctrl pend", v, 32'h1);
    step(3);
    rd(3'd0, v); chk("R8 ctrl landed", v, 32'h2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule